// File: doc/BRIEF.md
# Converter Fault Supervisor and Power-Good Sequencer

This block supervises a multiphase switching regulator controller from the digital side. Analog comparators report their decisions to it as asynchronous status bits:
- supply above the power-on-reset level;
- supply above the upper and lower lockout thresholds;
- enable;
- overvoltage, overcurrent and reference undervoltage;
- output inside its regulation window;
- compensation node ready.

It also receives the 6-bit voltage identification code. The block passes every input through a two-flop synchronizer. It then runs a sequencer state machine, which decides whether the PWM stage may switch, whether the external gate drivers are enabled, and whether the soft-start capacitor must be discharged.

Each fault class has its own handling. Overcurrent, reference undervoltage and overvoltage are latched until the supply drops below the power-on-reset level. Enable low, a shutdown identification code and supply brown-out are not latched, and the block recovers from them by itself. A brown-out ends only when the supply climbs back above the upper threshold, which gives the lockout its hysteresis. Power-good follows the output window, with one exception: a falling edge must persist for a full millisecond, counted in clocks from the `CLK_HZ` parameter, before the pin drops. Overvoltage forces power-good high.

The sequencer states are:
- `ST_POR`: the supply is below the power-on-reset level.
- `ST_UVLO`: first power-up. The supply is above POR but has not yet reached the upper threshold, and the drivers are enabled.
- `ST_IDLE`: disabled.
- `ST_SSTART`: soft-start. The block waits for compensation-ready.
- `ST_RUN`: switching.
- `ST_BROWN`: the supply has fallen below the lower threshold.
- `ST_VIDOFF`: a shutdown identification code is applied.
- `ST_OCL`: the overcurrent latch.
- `ST_REFL`: the reference-undervoltage latch.
- `ST_OVL`: the overvoltage latch.

The transitions are:
- Any state goes to POR when the supply falls below the power-on-reset level.
- POR goes to UVLO.
- Any state except POR and OVL goes to OVL on overvoltage. This check has the highest priority.
- Any unlatched state goes to OCL on overcurrent, and otherwise to REFL on reference undervoltage.
- UVLO and BROWN go to IDLE on the upper threshold.
- IDLE, SSTART, RUN and VIDOFF go to BROWN when the supply falls below the lower threshold.
- IDLE, SSTART and RUN go to VIDOFF on a shutdown code.
- VIDOFF goes to IDLE when the code changes.
- IDLE goes to SSTART on enable.
- SSTART and RUN go to IDLE when enable drops.
- SSTART goes to RUN on compensation-ready.

Top module: `pwr_fault_supervisor`

## Requirements
- R1: While the power-on-reset input is low, gate_en=0, drv_en=0, ss_dis=1 and pgood=0. This also applies after a digital reset.
- R2: After power-on-reset releases and before the upper supply threshold is reached, drv_en=1 and gate_en=0. Once the upper threshold is reached with enable low, drv_en=0.
- R3: Supply falling below the lower threshold while running gives gate_en=0, drv_en=0 and ss_dis=1. Between the two thresholds, a running converter keeps switching and a browned-out converter does not restart. Only the upper threshold restarts it.
- R4: With enable high, the soft-start phase gives drv_en=1, ss_dis=0 and gate_en=0. gate_en becomes 1 only after compensation-ready is seen high.
- R5: Enable low gives gate_en=0, drv_en=0 and ss_dis=1. It is not latched: raising enable restarts soft-start.
- R6: Overcurrent gives gate_en=0, drv_en=0 and ss_dis=1. These outputs persist after the overcurrent input clears, until the power-on-reset input goes low and high again.
- R7: Reference undervoltage gives gate_en=0, drv_en=0 and ss_dis=1. It is latched and cleared only by a power-on-reset cycle.
- R8: Overvoltage gives gate_en=0, drv_en=1, ss_dis=1 and pgood=1, even with the output out of window. It is latched until a power-on-reset cycle.
- R9: A code with vid[5:1] all ones, with vid[0] ignored, gives gate_en=0, drv_en=0 and ss_dis=1. Any other code, such as one with a zero in vid[5:1], releases the condition, and with enable high the block runs again.
- R10: pgood falls only after the synchronized window input has been low for CLK_HZ/1000 consecutive clocks. A shorter dip leaves pgood high throughout.
- R11: pgood rises within four clocks of the window input going high, in any state except the power-on-reset state. In the enable-low state it keeps following the window.
- R12: An out-of-window output changes none of gate_en, drv_en or ss_dis.
- R13: Overvoltage takes priority over overcurrent. If both appear together, or overvoltage follows an overcurrent latch, the overvoltage outputs apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock, CLK_HZ |
| rst_n | input | 1 | Active-low digital reset |
| por_ok_a | input | 1 | Supply above power-on-reset level (async) |
| vcc_hi_a | input | 1 | Supply above upper lockout threshold (async) |
| vcc_lo_a | input | 1 | Supply above lower lockout threshold (async) |
| enable_a | input | 1 | Converter enable (async) |
| ovp_a | input | 1 | Overvoltage comparator (async) |
| ocp_a | input | 1 | Summed-current limit comparator (async) |
| ref_uv_a | input | 1 | Reference undervoltage comparator (async) |
| out_win_a | input | 1 | Output inside regulation window (async) |
| comp_rdy_a | input | 1 | Compensation node above release level (async) |
| vid_a | input | 6 | Voltage identification code (async) |
| gate_en | output | 1 | Permit for PWM gate switching |
| pgood | output | 1 | Power-good, deglitched on falling edge |
| drv_en | output | 1 | External gate driver enable |
| ss_dis | output | 1 | Soft-start capacitor discharge request |

## Verification
The sequencer state decides gate_en, drv_en and ss_dis directly, so a wrong state shows up at those three pins three clocks after the input change that caused it. These three pins form a distinct pattern in most states. A latch that fails to hold appears once the fault input is removed: the converter restarts within about seven clocks instead of staying off. An error in the power-good counter shows only on pgood, and the window it can hide in is the millisecond deglitch itself. pgood is therefore sampled just before and just after the terminal count, and across a dip a few clocks shorter than the deglitch time.

// File: rtl/psv_pkg.sv
package psv_pkg;

    localparam int VID_W  = 6;
    localparam int STAT_W = 9;

    typedef enum logic [3:0] {
        ST_POR,
        ST_UVLO,
        ST_IDLE,
        ST_SSTART,
        ST_RUN,
        ST_BROWN,
        ST_VIDOFF,
        ST_OCL,
        ST_REFL,
        ST_OVL
    } psv_state_e;

    typedef struct packed {
        logic por;
        logic vhi;
        logic vlo;
        logic en;
        logic ovp;
        logic ocp;
        logic refuv;
        logic win;
        logic comp;
    } psv_status_t;

    // Shutdown code: upper five bits all ones, LSB ignored.
    function automatic logic vid_is_off(input logic [VID_W-1:0] code);
        return &code[VID_W-1:1];
    endfunction

endpackage

// File: rtl/psv_sync.sv
module psv_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/psv_pgood_filter.sv
module psv_pgood_filter #(
    parameter int TICKS = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic win_ok,
    input  logic force_hi,
    input  logic force_lo,
    output logic pgood
);

    localparam int CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] bad_cnt;
    logic          pg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pg_q    <= 1'b0;
            bad_cnt <= '0;
        end else if (force_lo) begin
            pg_q    <= 1'b0;
            bad_cnt <= '0;
        end else if (force_hi || win_ok) begin
            pg_q    <= 1'b1;
            bad_cnt <= '0;
        end else if (pg_q) begin
            if (bad_cnt == LAST) begin
                pg_q    <= 1'b0;
                bad_cnt <= '0;
            end else begin
                bad_cnt <= bad_cnt + 1'b1;
            end
        end else begin
            bad_cnt <= '0;
        end
    end

    assign pgood = pg_q;

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_cnt <= LAST);

    // R10
    pg_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pg_q) |-> ($past(force_lo) || ($past(!win_ok) && $past(bad_cnt) == LAST)));

    // R8
    pg_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_hi && !force_lo) |=> pg_q);

endmodule

// File: rtl/psv_sequencer.sv
module psv_sequencer
    import psv_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  psv_status_t st,
    input  logic        vid_off,
    output psv_state_e  state,
    output logic        gate_en,
    output logic        drv_en,
    output logic        ss_dis
);

    psv_state_e cur, nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= ST_POR;
        else        cur <= nxt;
    end

    // Next-state decision, fault priority: POR > OVP > latched > OCP > REFUV
    always_comb begin
        nxt = cur;
        if (!st.por) begin
            nxt = ST_POR;
        end else if (cur == ST_POR) begin
            nxt = ST_UVLO;
        end else if (cur == ST_OVL) begin
            nxt = ST_OVL;
        end else if (st.ovp) begin
            nxt = ST_OVL;
        end else if (cur == ST_OCL || cur == ST_REFL) begin
            nxt = cur;
        end else if (st.ocp) begin
            nxt = ST_OCL;
        end else if (st.refuv) begin
            nxt = ST_REFL;
        end else begin
            unique case (cur)
                ST_UVLO, ST_BROWN: begin
                    if (st.vhi) nxt = ST_IDLE;
                end
                ST_IDLE: begin
                    if (!st.vlo)     nxt = ST_BROWN;
                    else if (vid_off) nxt = ST_VIDOFF;
                    else if (st.en)   nxt = ST_SSTART;
                end
                ST_SSTART, ST_RUN: begin
                    if (!st.vlo)                       nxt = ST_BROWN;
                    else if (vid_off)                  nxt = ST_VIDOFF;
                    else if (!st.en)                   nxt = ST_IDLE;
                    else if (cur == ST_SSTART && st.comp) nxt = ST_RUN;
                end
                ST_VIDOFF: begin
                    if (!st.vlo)      nxt = ST_BROWN;
                    else if (!vid_off) nxt = ST_IDLE;
                end
                default: nxt = cur;
            endcase
        end
    end

    // Output decode per state
    always_comb begin
        gate_en = 1'b0;
        drv_en  = 1'b0;
        ss_dis  = 1'b1;
        unique case (cur)
            ST_POR:    ;
            ST_UVLO:   drv_en = 1'b1;
            ST_IDLE:   ;
            ST_SSTART: begin
                drv_en = 1'b1;
                ss_dis = 1'b0;
            end
            ST_RUN: begin
                gate_en = 1'b1;
                drv_en  = 1'b1;
                ss_dis  = 1'b0;
            end
            ST_BROWN:  ;
            ST_VIDOFF: ;
            ST_OCL:    ;
            ST_REFL:   ;
            ST_OVL:    drv_en = 1'b1;
            default:   ;
        endcase
    end

    assign state = cur;

    // R4
    gate_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_en) |-> $past(st.comp));

    // R12
    gate_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_en |-> (drv_en && !ss_dis));

    // R6
    ocl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == ST_OCL) |=> (cur == ST_OCL || cur == ST_OVL || cur == ST_POR));

    // R8
    ovl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == ST_OVL) |=> (cur == ST_OVL || cur == ST_POR));

    // R9
    vid_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vid_off |=> !gate_en);

endmodule

// File: rtl/pwr_fault_supervisor.sv
module pwr_fault_supervisor
    import psv_pkg::*;
#(
    parameter int CLK_HZ      = 100_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_ok_a,
    input  logic             vcc_hi_a,
    input  logic             vcc_lo_a,
    input  logic             enable_a,
    input  logic             ovp_a,
    input  logic             ocp_a,
    input  logic             ref_uv_a,
    input  logic             out_win_a,
    input  logic             comp_rdy_a,
    input  logic [VID_W-1:0] vid_a,
    output logic             gate_en,
    output logic             pgood,
    output logic             drv_en,
    output logic             ss_dis
);

    localparam int TICKS = (CLK_HZ / 1000 < 2) ? 2 : CLK_HZ / 1000;
    localparam int RAW_W = STAT_W + VID_W;

    logic [RAW_W-1:0] raw, synced;
    psv_status_t      st;
    logic [VID_W-1:0] vid_s;
    psv_state_e       state;

    assign raw = {por_ok_a, vcc_hi_a, vcc_lo_a, enable_a, ovp_a, ocp_a,
                  ref_uv_a, out_win_a, comp_rdy_a, vid_a};

    psv_sync #(.WIDTH(RAW_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw),
        .q     (synced)
    );

    assign st    = psv_status_t'(synced[RAW_W-1:VID_W]);
    assign vid_s = synced[VID_W-1:0];

    psv_sequencer u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .st      (st),
        .vid_off (vid_is_off(vid_s)),
        .state   (state),
        .gate_en (gate_en),
        .drv_en  (drv_en),
        .ss_dis  (ss_dis)
    );

    psv_pgood_filter #(.TICKS(TICKS)) u_pg (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_ok   (st.win),
        .force_hi (state == ST_OVL),
        .force_lo (!st.por),
        .pgood    (pgood)
    );

    // R1
    por_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st.por |=> (!gate_en && !drv_en && ss_dis && !pgood));

endmodule

// File: tb/sim_pwr_fault_supervisor.sv
`timescale 1ns/1ps
module sim_pwr_fault_supervisor;

    localparam int CLK_HZ = 20000;
    localparam int TICKS  = CLK_HZ / 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic por_ok_a = 0, vcc_hi_a = 0, vcc_lo_a = 0, enable_a = 0;
    logic ovp_a = 0, ocp_a = 0, ref_uv_a = 0, out_win_a = 0, comp_rdy_a = 0;
    logic [5:0] vid_a = 6'b000000;
    logic gate_en, pgood, drv_en, ss_dis;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    pwr_fault_supervisor #(.CLK_HZ(CLK_HZ)) u0 (
        .clk(clk), .rst_n(rst_n), .por_ok_a(por_ok_a), .vcc_hi_a(vcc_hi_a),
        .vcc_lo_a(vcc_lo_a), .enable_a(enable_a), .ovp_a(ovp_a), .ocp_a(ocp_a),
        .ref_uv_a(ref_uv_a), .out_win_a(out_win_a), .comp_rdy_a(comp_rdy_a),
        .vid_a(vid_a), .gate_en(gate_en), .pgood(pgood), .drv_en(drv_en),
        .ss_dis(ss_dis)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // gate, drv, ss in one call
    task automatic chk3(input string req, input logic g, input logic d, input logic s);
        chk(req, "gate_en", gate_en, g);
        chk(req, "drv_en", drv_en, d);
        chk(req, "ss_dis", ss_dis, s);
    endtask

    task automatic por_cycle(input string req);
        por_ok_a = 0;
        cyc(4);
        chk3("R1", 0, 0, 1);
        chk("R1", "pgood", pgood, 0);
        por_ok_a = 1;
        cyc(8);
        chk(req, "gate_en after POR cycle", gate_en, 1);
        cyc(2);
    endtask

    task automatic t_reset;
        cyc(3);
        rst_n = 1;
        cyc(3);
        chk3("R1", 0, 0, 1);
        chk("R1", "pgood", pgood, 0);
    endtask

    task automatic t_powerup;
        por_ok_a = 1;
        cyc(4);
        chk3("R2", 0, 1, 1);
        vcc_lo_a = 1;
        vcc_hi_a = 1;
        cyc(4);
        chk3("R2", 0, 0, 1);
    endtask

    task automatic t_softstart;
        enable_a = 1;
        cyc(4);
        chk3("R4", 0, 1, 0);
        cyc(6);
        chk("R4", "gate held without comp", gate_en, 0);
        comp_rdy_a = 1;
        cyc(4);
        chk3("R4", 1, 1, 0);
        out_win_a = 1;
        cyc(4);
        chk("R11", "pgood rise", pgood, 1);
    endtask

    task automatic t_window;
        logic stayed;
        out_win_a = 0;
        cyc(TICKS - 5);
        out_win_a = 1;
        stayed = 1;
        for (int i = 0; i < 10; i++) begin
            cyc(1);
            if (pgood !== 1'b1) stayed = 0;
        end
        chk("R10", "pgood across short dip", stayed, 1);
        out_win_a = 0;
        cyc(TICKS);
        chk("R10", "pgood before deglitch end", pgood, 1);
        chk3("R12", 1, 1, 0);
        cyc(3);
        chk("R10", "pgood after deglitch", pgood, 0);
        chk3("R12", 1, 1, 0);
        out_win_a = 1;
        cyc(4);
        chk("R11", "pgood recover", pgood, 1);
    endtask

    task automatic t_enable;
        enable_a = 0;
        cyc(4);
        chk3("R5", 0, 0, 1);
        out_win_a = 0;
        cyc(TICKS + 5);
        chk("R11", "pgood follows window when disabled", pgood, 0);
        out_win_a = 1;
        cyc(4);
        chk("R11", "pgood rises when disabled", pgood, 1);
        enable_a = 1;
        cyc(6);
        chk3("R5", 1, 1, 0);
    endtask

    task automatic t_vid;
        vid_a = 6'b111101;
        cyc(5);
        chk("R9", "non-shutdown code keeps gate", gate_en, 1);
        vid_a = 6'b111110;
        cyc(4);
        chk3("R9", 0, 0, 1);
        vid_a = 6'b111111;
        cyc(4);
        chk3("R9", 0, 0, 1);
        vid_a = 6'b011111;
        cyc(7);
        chk3("R9", 1, 1, 0);
    endtask

    task automatic t_brown;
        vcc_hi_a = 0;
        cyc(5);
        chk("R3", "run between thresholds", gate_en, 1);
        vcc_lo_a = 0;
        cyc(4);
        chk3("R3", 0, 0, 1);
        vcc_lo_a = 1;
        cyc(6);
        chk3("R3", 0, 0, 1);
        vcc_hi_a = 1;
        cyc(7);
        chk3("R3", 1, 1, 0);
    endtask

    task automatic t_ocp;
        ocp_a = 1;
        cyc(4);
        chk3("R6", 0, 0, 1);
        ocp_a = 0;
        cyc(8);
        chk3("R6", 0, 0, 1);
        por_cycle("R6");
    endtask

    task automatic t_refuv;
        ref_uv_a = 1;
        cyc(4);
        chk3("R7", 0, 0, 1);
        ref_uv_a = 0;
        cyc(8);
        chk3("R7", 0, 0, 1);
        por_cycle("R7");
    endtask

    task automatic t_ovp;
        ovp_a = 1;
        out_win_a = 0;
        cyc(4);
        chk3("R8", 0, 1, 1);
        cyc(TICKS + 10);
        chk("R8", "pgood forced high", pgood, 1);
        ovp_a = 0;
        cyc(8);
        chk3("R8", 0, 1, 1);
        out_win_a = 1;
        por_cycle("R8");
    endtask

    task automatic t_prio;
        ovp_a = 1;
        ocp_a = 1;
        cyc(4);
        chk3("R13", 0, 1, 1);
        ovp_a = 0;
        ocp_a = 0;
        por_cycle("R13");
        ocp_a = 1;
        cyc(4);
        chk("R13", "ocp latch drv", drv_en, 0);
        ocp_a = 0;
        cyc(2);
        ovp_a = 1;
        cyc(4);
        chk3("R13", 0, 1, 1);
        ovp_a = 0;
        por_cycle("R13");
    endtask

    initial begin
        t_reset();
        t_powerup();
        t_softstart();
        t_window();
        t_enable();
        t_vid();
        t_brown();
        t_ocp();
        t_refuv();
        t_ovp();
        t_prio();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule